// File: doc/BRIEF.md
# DAC Sample Strobe and Test-Pattern Generator

This block runs in the fast clock domain of a serial DAC path. It produces a periodic one-cycle convert strobe and, with each strobe, a parallel sample word for a downstream serializer. A 2-bit rate input selects one of four sample periods. Each period is a power-of-two multiple of a base divider count. With a 120 MHz clock and the default base of 120 cycles, the four periods give 1 MHz, 500 kHz, 250 kHz and 125 kHz. Every rate is slower than one 16-bit serial frame plus the clock-crossing delay.

The sample word carries a fixed control byte in its upper bits and an 8-bit pattern value in its lower bits. The pattern is a triangle (a ramp up, then a ramp down) or a square wave (a low level and a high level that alternate). A mode input chooses which one is placed in the word. Both generators step on every issued sample, so switching modes never restarts a pattern.

A ready input from the serializer gates the strobe. When a divider period ends while the serializer is busy, no strobe is issued. The divider keeps its phase, so the rate stays fixed. The pattern does not step, and a saturating counter records the lost sample.

Top module: `dac_pattern_gen`

## Requirements
- R1: While rst_n is low (asynchronous, active low), convert_o is 0, sample_o is all zeros and drop_cnt_o is 0.
- R2: Let P be BASE_DIV shifted left by rate_sel_i, so codes 0, 1, 2 and 3 give 1x, 2x, 4x and 8x BASE_DIV cycles. When rst_n is released before rising edge 1, a divider period ends at every rising edge k with k a multiple of P. With ready high, convert_o is high for exactly the one cycle after such an edge. It is never high in the first cycle after reset.
- R3: If ser_ready_i is low at the edge where a period ends, convert_o stays low for that period. The following periods still end on the multiples of P.
- R4: Each period that ends without a strobe adds one to drop_cnt_o in the same edge. The counter saturates at 2^DROP_W-1 and does not change at an edge that issues a strobe.
- R5: Number the issued samples n = 0, 1, 2, and so on from reset. The triangle value of sample n is m for m = n mod 510 when m <= 255, and 510-m otherwise.
- R6: The square value of sample n is 0x00 when floor(n/128) is even and 0xFF when it is odd.
- R7: A dropped period does not advance either pattern. The next issued sample carries the next index n.
- R8: sample_o equals {CTRL_BITS, value} (CTRL_BITS in bits 15:8, value in bits 7:0). It is loaded at the edge that raises convert_o and holds its value until the next strobe.
- R9: The low byte is the triangle value when wave_sel_i is 1 and the square value when it is 0. The level of wave_sel_i at the issuing edge decides. Both patterns advance on every issued sample, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rate_sel_i | input | 2 | Sample period select (BASE_DIV << code) |
| wave_sel_i | input | 1 | 1 = triangle, 0 = square |
| ser_ready_i | input | 1 | Serializer can accept a sample |
| convert_o | output | 1 | One-cycle convert strobe |
| sample_o | output | 16 | Control byte and pattern value |
| drop_cnt_o | output | DROP_W | Saturating count of suppressed strobes |

## Verification
A divider that wraps at the wrong count moves the strobe off the multiples of P, and this shows at the next period end, within one period of reset. A wrong pattern index, direction flag or square phase counter shows in the low byte of the next issued sample. A fault in the triangle turning points shows first at the sample 255 or 510 positions, and a fault in the square toggle shows at sample 128. A pattern that steps on a dropped period shows as a skipped value in the first strobe after the drop. A counter that fails to saturate shows once the drops exceed the counter range.

// File: rtl/dac_pattern_pkg.sv
package dac_pattern_pkg;

  typedef enum logic {
    WAVE_SQUARE   = 1'b0,
    WAVE_TRIANGLE = 1'b1
  } wave_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;

  localparam int unsigned RATE_SEL_W = 2;
  localparam int unsigned NUM_RATES  = 1 << RATE_SEL_W;

endpackage

// File: rtl/dac_rate_div.sv
module dac_rate_div
  import dac_pattern_pkg::*;
#(
  parameter int unsigned BASE_DIV = 120
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RATE_SEL_W-1:0] rate_sel_i,
  output logic                  tick_o
);

  localparam int unsigned MAX_PERIOD = BASE_DIV << (NUM_RATES - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] term_tab [NUM_RATES];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_term
    localparam int unsigned PERIOD = BASE_DIV << g;
    assign term_tab[g] = CNT_W'(PERIOD - 1);
  end

  assign term = term_tab[rate_sel_i];
  assign wrap = (cnt_q >= term);

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = wrap;

endmodule

// File: rtl/dac_tri_source.sv
module dac_tri_source
  import dac_pattern_pkg::*;
#(
  parameter int unsigned AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [AMP_W-1:0] val_o
);

  localparam logic [AMP_W-1:0] TOP = {AMP_W{1'b1}};

  logic [AMP_W-1:0] val_q;
  logic [AMP_W-1:0] val_d;
  ramp_dir_e        dir_q;
  ramp_dir_e        dir_d;

  always_comb begin
    val_d = val_q;
    dir_d = dir_q;
    if (adv_i) begin
      if (dir_q == DIR_UP) begin
        if (val_q == TOP) begin
          dir_d = DIR_DOWN;
          val_d = val_q - 1'b1;
        end else begin
          val_d = val_q + 1'b1;
        end
      end else begin
        if (val_q == '0) begin
          dir_d = DIR_UP;
          val_d = val_q + 1'b1;
        end else begin
          val_d = val_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= DIR_UP;
    end else if (adv_i) begin
      val_q <= val_d;
      dir_q <= dir_d;
    end
  end

  assign val_o = val_q;

endmodule

// File: rtl/dac_square_source.sv
module dac_square_source #(
  parameter int unsigned AMP_W    = 8,
  parameter int unsigned HALF_LEN = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [AMP_W-1:0] val_o
);

  localparam int unsigned HC_W = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_LEN - 1);

  logic [HC_W-1:0] hcnt_q;
  logic [HC_W-1:0] hcnt_d;
  logic            lvl_q;
  logic            lvl_d;
  logic            half_end;

  assign half_end = (hcnt_q == HC_LAST);

  always_comb begin
    hcnt_d = hcnt_q;
    lvl_d  = lvl_q;
    if (adv_i) begin
      if (half_end) begin
        hcnt_d = '0;
        lvl_d  = ~lvl_q;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lvl_q  <= 1'b0;
    end else if (adv_i) begin
      hcnt_q <= hcnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign val_o = {AMP_W{lvl_q}};

endmodule

// File: rtl/dac_drop_counter.sv
module dac_drop_counter #(
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  output logic [DROP_W-1:0] cnt_o
);

  logic [DROP_W-1:0] cnt_q;
  logic [DROP_W-1:0] cnt_d;
  logic              full;
  logic              cnt_en;

  assign full   = &cnt_q;
  assign cnt_en = inc_i && !full;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dac_pattern_gen.sv
module dac_pattern_gen
  import dac_pattern_pkg::*;
#(
  parameter int unsigned               BASE_DIV  = 120,
  parameter int unsigned               DATA_W    = 16,
  parameter int unsigned               AMP_W     = 8,
  parameter int unsigned               HALF_LEN  = 128,
  parameter int unsigned               DROP_W    = 16,
  parameter logic [DATA_W-AMP_W-1:0]   CTRL_BITS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RATE_SEL_W-1:0] rate_sel_i,
  input  logic                  wave_sel_i,
  input  logic                  ser_ready_i,
  output logic                  convert_o,
  output logic [DATA_W-1:0]     sample_o,
  output logic [DROP_W-1:0]     drop_cnt_o
);

  logic              tick;
  logic              issue;
  logic              drop;
  logic [AMP_W-1:0]  tri_val;
  logic [AMP_W-1:0]  sq_val;
  logic [AMP_W-1:0]  sel_val;
  logic              conv_q;
  logic              conv_d;
  logic [DATA_W-1:0] smp_q;
  logic [DATA_W-1:0] smp_d;
  wave_mode_e        mode;

  dac_rate_div #(
    .BASE_DIV (BASE_DIV)
  ) div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick)
  );

  assign issue = tick && ser_ready_i;
  assign drop  = tick && !ser_ready_i;

  dac_tri_source #(
    .AMP_W (AMP_W)
  ) tri_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (issue),
    .val_o (tri_val)
  );

  dac_square_source #(
    .AMP_W    (AMP_W),
    .HALF_LEN (HALF_LEN)
  ) sq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (issue),
    .val_o (sq_val)
  );

  dac_drop_counter #(
    .DROP_W (DROP_W)
  ) drop_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (drop),
    .cnt_o (drop_cnt_o)
  );

  assign mode = wave_mode_e'(wave_sel_i);

  always_comb begin
    sel_val = (mode == WAVE_TRIANGLE) ? tri_val : sq_val;
    smp_d   = {CTRL_BITS, sel_val};
    conv_d  = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
    end else begin
      conv_q <= conv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (issue) begin
      smp_q <= smp_d;
    end
  end

  assign convert_o = conv_q;
  assign sample_o  = smp_q;

endmodule

// File: rtl/dac_pattern_gen_chk.sv
module dac_pattern_gen_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AMP_W  = 8,
  parameter int unsigned DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wave_sel_i,
  input logic              ser_ready_i,
  input logic              convert_o,
  input logic [DATA_W-1:0] sample_o,
  input logic [DROP_W-1:0] drop_cnt_o
);

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    convert_o |=> !convert_o); // R2

  AST_READY_GATES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    convert_o |-> $past(ser_ready_i)); // R3

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt_o == $past(drop_cnt_o)) ||
    (drop_cnt_o == DROP_W'($past(drop_cnt_o) + 1'b1))); // R4

  AST_DROP_HOLD_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    convert_o |-> $stable(drop_cnt_o)); // R4

  AST_SQUARE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (convert_o && !$past(wave_sel_i)) |->
    ((sample_o[AMP_W-1:0] == '0) || (&sample_o[AMP_W-1:0]))); // R6

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !convert_o |-> $stable(sample_o)); // R8

endmodule

bind dac_pattern_gen dac_pattern_gen_chk #(
  .DATA_W (DATA_W),
  .AMP_W  (AMP_W),
  .DROP_W (DROP_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wave_sel_i  (wave_sel_i),
  .ser_ready_i (ser_ready_i),
  .convert_o   (convert_o),
  .sample_o    (sample_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/dac_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module dac_pattern_gen_tb_top;

  localparam int unsigned BASE = 5;
  localparam int unsigned DW   = 16;
  localparam int unsigned AW   = 8;
  localparam int unsigned HALF = 128;
  localparam int unsigned DRW  = 4;
  localparam logic [7:0]  CTRL = 8'hA5;
  localparam int          DMAX = (1 << DRW) - 1;

  logic           clk;
  logic           rst_n;
  logic [1:0]     rate_sel;
  logic           wave_sel;
  logic           ser_ready;
  logic           convert;
  logic [DW-1:0]  sample;
  logic [DRW-1:0] drops;

  int n_chk;
  int n_fail;
  bit done;

  dac_pattern_gen #(
    .BASE_DIV  (BASE),
    .DATA_W    (DW),
    .AMP_W     (AW),
    .HALF_LEN  (HALF),
    .DROP_W    (DRW),
    .CTRL_BITS (CTRL)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel_i  (rate_sel),
    .wave_sel_i  (wave_sel),
    .ser_ready_i (ser_ready),
    .convert_o   (convert),
    .sample_o    (sample),
    .drop_cnt_o  (drops)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tri_f(input int n);
    int m;
    m = n % 510;
    return (m <= 255) ? 8'(m) : 8'(510 - m);
  endfunction

  function automatic logic [7:0] sq_f(input int n);
    return (((n / HALF) % 2) == 1) ? 8'hFF : 8'h00;
  endfunction

  function automatic bit rdy_f(input int kind, input int k);
    if (kind == 0) return 1'b1;
    return !(((k / 7) % 3) == 0);
  endfunction

  function automatic bit mode_f(input int kind, input int fixed, input int k);
    if (kind == 0) return fixed[0];
    return ((k / 50) % 2) == 1;
  endfunction

  // mkind 0: fixed mode mfix; 2: alternating. rkind 0: always ready; 1: pattern.
  task automatic run(input int rate, input int mkind, input int mfix,
                     input int rkind, input int ncyc, input string wtag);
    int p;
    int n;
    int dcnt;
    logic [DW-1:0] exp_s;
    bit exp_c;
    bit tk;
    rst_n     = 1'b0;
    rate_sel  = 2'(rate);
    wave_sel  = mode_f(mkind, mfix, 1);
    ser_ready = rdy_f(rkind, 1);
    repeat (3) @(negedge clk);
    check(convert == 1'b0, "R1", "reset convert", convert, 0);
    check(sample == '0, "R1", "reset sample", sample, 0);
    check(drops == '0, "R1", "reset drops", drops, 0);
    rst_n = 1'b1;
    p     = BASE << rate;
    n     = 0;
    dcnt  = 0;
    exp_s = '0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      tk    = (k % p) == 0;
      exp_c = tk && rdy_f(rkind, k);
      if (tk && !exp_c) dcnt++;
      if (exp_c) begin
        exp_s = {CTRL, mode_f(mkind, mfix, k) ? tri_f(n) : sq_f(n)};
        n++;
      end
      if (tk && !exp_c)
        check(convert == 1'b0, "R3", "strobe while busy", convert, 0);
      else
        check(convert == exp_c, "R2", "strobe timing", convert, exp_c);
      if (exp_c)
        check(sample == exp_s, wtag, "sample word", sample, exp_s);
      else
        check(sample == exp_s, "R8", "sample hold", sample, exp_s);
      check(int'(drops) == ((dcnt > DMAX) ? DMAX : dcnt), "R4", "drop count",
            drops, (dcnt > DMAX) ? DMAX : dcnt);
      wave_sel  = mode_f(mkind, mfix, k + 1);
      ser_ready = rdy_f(rkind, k + 1);
    end
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    rate_sel  = 2'd0;
    wave_sel  = 1'b1;
    ser_ready = 1'b1;
    // R5: full triangle cycles at the fastest rate
    run(0, 0, 1, 0, 1100 * BASE, "R5");
    // R6: square wave at each slower rate
    run(1, 0, 0, 0, 300 * (BASE << 1), "R6");
    run(2, 0, 0, 0, 300 * (BASE << 2), "R6");
    run(3, 0, 0, 0, 300 * (BASE << 3), "R6");
    // R7: drops leave the pattern index alone, triangle mode
    run(0, 0, 1, 1, 700 * BASE, "R7");
    // R9: mode toggles with busy periods, patterns keep stepping
    run(1, 2, 0, 1, 400 * (BASE << 1), "R9");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule